// File: doc/BRIEF.md
# Operand Address Generation Unit

This unit turns an addressing request from the decode stage of a small 8-bit microcontroller core into the effective address of the operand and the memory space that holds it. A request names an addressing mode and carries the register field and direct-address byte taken from the opcode. It also carries the live core state: the two bank-select bits, the stack pointer, the 16-bit data pointer, the program counter and the accumulator.

Register operands live in a register-file RAM that is split into four banks of eight. The bank is picked at run time. For pointer-indirect access the unit reads the pointer register R0 or R1 of the current bank through a combinational read port. It then forms the result in the same cycle as the request and registers it. Every result therefore appears exactly one clock after its request, together with a valid strobe. Table lookups and computed jumps are built by adding the unsigned accumulator to a 16-bit base, with wrap-around. Requests that break the rules of a mode raise an illegal flag and carry no address.

Top module: `oper_addr_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, out_valid, out_illegal and out_jump are 0, out_addr is 0 and out_space is 3 (none).
- R2: Mode 0 (register) yields the address bank_sel*8 + req_reg in space 0 (internal data), whatever req_ext and req_write are.
- R3: Mode 1 (direct) yields req_dir zero-extended in space 0. If req_ext is 1, the request is illegal.
- R4: Mode 2 (pointer-register indirect) drives rf_addr = bank_sel*8 + req_reg[0] during the request cycle. The result is the byte read there, zero-extended. The space is 1 (external data) when req_ext is 1 and 0 otherwise.
- R5: Mode 3 (stack-pointer indirect) yields sp zero-extended. The space is 1 when req_ext is 1 and 0 otherwise.
- R6: Mode 4 (16-bit indirect) yields dptr in space 1, whatever req_ext is.
- R7: Mode 5 yields dptr + acc and mode 6 yields pc + acc, in space 2 (program memory). The accumulator is unsigned and the sum wraps modulo 2^16. Asking either mode with req_write = 1 is illegal.
- R8: Mode 7 (computed jump) yields dptr + acc, wrapped, in space 2, with out_jump = 1. Asking it with req_write = 1 is illegal.
- R9: An illegal request gives out_illegal = 1, out_addr = 0, out_space = 3 and out_jump = 0.
- R10: out_valid is 1 exactly in the cycle after each request. In cycles without a request, out_addr, out_space, out_illegal and out_jump keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 3 | Addressing mode, encoded 0..7 as in R2 to R8 |
| req_write | input | 1 | Request is for a store |
| req_ext | input | 1 | 8-bit indirect targets external data |
| req_reg | input | 3 | Register field from the opcode |
| req_dir | input | 8 | Direct-address byte |
| bank_sel | input | 2 | Active register bank |
| sp | input | 8 | Stack pointer |
| dptr | input | 16 | Data pointer |
| pc | input | 16 | Program counter |
| acc | input | 8 | Accumulator |
| rf_addr | output | 5 | Register-file read address |
| rf_rdata | input | 8 | Register-file read data (combinational) |
| out_valid | output | 1 | Result valid |
| out_addr | output | 16 | Effective address |
| out_space | output | 2 | 0 internal, 1 external, 2 program, 3 none |
| out_illegal | output | 1 | Request broke a mode rule |
| out_jump | output | 1 | Address is a jump destination |

## Verification
Two kinds of state can meet in one cycle: the register-file read for one request, and the bank select or pointer contents left behind by the request just before it. Back-to-back requests therefore switch bank_sel and the mode on every clock, and pointer reads are mixed with adder and illegal cases, both by a directed sequence and by seeded random traffic. Each result is judged one cycle later against a bench model. That model reads its own register-file array with the bank that was current when the request was made, not the bank current when the result appears.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        MODE_REG    = 3'd0,
        MODE_DIR    = 3'd1,
        MODE_IND_R  = 3'd2,
        MODE_IND_SP = 3'd3,
        MODE_IND_DP = 3'd4,
        MODE_IDX_DP = 3'd5,
        MODE_IDX_PC = 3'd6,
        MODE_JMP_DP = 3'd7
    } agu_mode_e;

    typedef enum logic [1:0] {
        SPC_IDATA = 2'd0,
        SPC_XDATA = 2'd1,
        SPC_CODE  = 2'd2,
        SPC_NONE  = 2'd3
    } agu_space_e;

    typedef struct packed {
        logic       illegal;
        logic       jump;
        agu_space_e space;
    } agu_tag_t;

    // Modes whose target is program memory and may only be read.
    function automatic logic is_code_mode(agu_mode_e m);
        return (m == MODE_IDX_DP) || (m == MODE_IDX_PC) || (m == MODE_JMP_DP);
    endfunction

    // Rule check shared by the resolver.
    function automatic logic breaks_rule(agu_mode_e m, logic wr, logic ext);
        if (is_code_mode(m)) return wr;
        if (m == MODE_DIR)   return ext;
        return 1'b0;
    endfunction

    // Space chosen by the 8-bit indirect modes.
    function automatic agu_space_e byte_ptr_space(logic ext);
        return ext ? SPC_XDATA : SPC_IDATA;
    endfunction

endpackage

// File: rtl/agu_bank_port.sv
module agu_bank_port #(
    parameter  int NUM_BANKS     = 4,
    parameter  int REGS_PER_BANK = 8,
    localparam int BANK_W        = $clog2(NUM_BANKS),
    localparam int REG_W         = $clog2(REGS_PER_BANK),
    localparam int RF_AW         = BANK_W + REG_W
) (
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [REG_W-1:0]  reg_field,
    output logic [RF_AW-1:0]  ptr_rd_addr,
    output logic [RF_AW-1:0]  reg_loc
);
    // Location of Rn inside the active bank.
    assign reg_loc = {bank_sel, reg_field};

    // Pointer registers are the two lowest of the bank; field bit 0 picks one.
    generate
        if (REG_W > 1) begin : g_wide
            assign ptr_rd_addr = {bank_sel, {(REG_W-1){1'b0}}, reg_field[0]};
        end else begin : g_narrow
            assign ptr_rd_addr = {bank_sel, reg_field[0]};
        end
    endgenerate
endmodule

// File: rtl/agu_index_adder.sv
module agu_index_adder #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              use_pc,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] acc,
    output logic [ADDR_W-1:0] sum
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offset;

    assign base = use_pc ? pc : dptr;

    // Unsigned zero extension of the accumulator; carry out of the top bit is dropped.
    generate
        if (ADDR_W > DATA_W) begin : g_ext
            assign offset = {{(ADDR_W-DATA_W){1'b0}}, acc};
        end else begin : g_trunc
            assign offset = acc[ADDR_W-1:0];
        end
    endgenerate

    assign sum = base + offset;
endmodule

// File: rtl/agu_resolve.sv
module agu_resolve
    import agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RF_AW  = 5
) (
    input  agu_mode_e         mode,
    input  logic              wr,
    input  logic              ext,
    input  logic [DATA_W-1:0] dir,
    input  logic [DATA_W-1:0] sp,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [DATA_W-1:0] ptr_val,
    input  logic [RF_AW-1:0]  reg_loc,
    input  logic [ADDR_W-1:0] idx_sum,
    output logic [ADDR_W-1:0] addr,
    output agu_tag_t          tag
);
    localparam int PAD_D = ADDR_W - DATA_W;
    localparam int PAD_R = ADDR_W - RF_AW;

    logic [ADDR_W-1:0] cand_addr;
    agu_tag_t          cand_tag;
    logic              bad;

    always_comb begin
        cand_addr = '0;
        cand_tag  = '{illegal: 1'b0, jump: 1'b0, space: SPC_IDATA};
        unique case (mode)
            MODE_REG:    cand_addr = {{PAD_R{1'b0}}, reg_loc};
            MODE_DIR:    cand_addr = {{PAD_D{1'b0}}, dir};
            MODE_IND_R: begin
                cand_addr      = {{PAD_D{1'b0}}, ptr_val};
                cand_tag.space = byte_ptr_space(ext);
            end
            MODE_IND_SP: begin
                cand_addr      = {{PAD_D{1'b0}}, sp};
                cand_tag.space = byte_ptr_space(ext);
            end
            MODE_IND_DP: begin
                cand_addr      = dptr;
                cand_tag.space = SPC_XDATA;
            end
            MODE_IDX_DP, MODE_IDX_PC: begin
                cand_addr      = idx_sum;
                cand_tag.space = SPC_CODE;
            end
            MODE_JMP_DP: begin
                cand_addr      = idx_sum;
                cand_tag.space = SPC_CODE;
                cand_tag.jump  = 1'b1;
            end
            default: ;
        endcase
    end

    assign bad = breaks_rule(mode, wr, ext);

    always_comb begin
        if (bad) begin
            addr = '0;
            tag  = '{illegal: 1'b1, jump: 1'b0, space: SPC_NONE};
        end else begin
            addr = cand_addr;
            tag  = cand_tag;
        end
    end
endmodule

// File: rtl/oper_addr_gen.sv
module oper_addr_gen
    import agu_pkg::*;
#(
    parameter  int ADDR_W        = 16,
    parameter  int DATA_W        = 8,
    parameter  int NUM_BANKS     = 4,
    parameter  int REGS_PER_BANK = 8,
    localparam int BANK_W        = $clog2(NUM_BANKS),
    localparam int REG_W         = $clog2(REGS_PER_BANK),
    localparam int RF_AW         = BANK_W + REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic              req_write,
    input  logic              req_ext,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_dir,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [DATA_W-1:0] sp,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] acc,
    output logic [RF_AW-1:0]  rf_addr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [1:0]        out_space,
    output logic              out_illegal,
    output logic              out_jump
);
    agu_mode_e         mode;
    logic [RF_AW-1:0]  reg_loc;
    logic [ADDR_W-1:0] idx_sum;
    logic [ADDR_W-1:0] next_addr;
    agu_tag_t          next_tag;
    agu_tag_t          tag_q;

    assign mode = agu_mode_e'(req_mode);

    agu_bank_port #(
        .NUM_BANKS     (NUM_BANKS),
        .REGS_PER_BANK (REGS_PER_BANK)
    ) u_bank (
        .bank_sel    (bank_sel),
        .reg_field   (req_reg),
        .ptr_rd_addr (rf_addr),
        .reg_loc     (reg_loc)
    );

    agu_index_adder #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_add (
        .use_pc (mode == MODE_IDX_PC),
        .dptr   (dptr),
        .pc     (pc),
        .acc    (acc),
        .sum    (idx_sum)
    );

    agu_resolve #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RF_AW  (RF_AW)
    ) u_res (
        .mode    (mode),
        .wr      (req_write),
        .ext     (req_ext),
        .dir     (req_dir),
        .sp      (sp),
        .dptr    (dptr),
        .ptr_val (rf_rdata),
        .reg_loc (reg_loc),
        .idx_sum (idx_sum),
        .addr    (next_addr),
        .tag     (next_tag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            tag_q     <= '{illegal: 1'b0, jump: 1'b0, space: SPC_NONE};
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_addr <= next_addr;
                tag_q    <= next_tag;
            end
        end
    end

    assign out_space   = tag_q.space;
    assign out_illegal = tag_q.illegal;
    assign out_jump    = tag_q.jump;
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
    parameter int ADDR_W = 16,
    parameter int RF_AW  = 5,
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [2:0]        req_mode,
    input logic              req_write,
    input logic [BANK_W-1:0] bank_sel,
    input logic [ADDR_W-1:0] dptr,
    input logic [RF_AW-1:0]  rf_addr,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [1:0]        out_space,
    input logic              out_illegal,
    input logic              out_jump
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal && !out_jump));

    assert_valid_after_req_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    assert_illegal_no_addr_R9: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_addr == '0 && out_space == 2'd3 && !out_jump));

    assert_jump_in_code_R8: assert property (@(posedge clk) disable iff (rst)
        out_jump |-> (out_space == 2'd2 && !out_illegal));

    assert_ptr_read_bank_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'd2) |-> (rf_addr[RF_AW-1 -: BANK_W] == bank_sel));

    assert_dptr_indirect_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'd4) |=> (out_addr == $past(dptr) && out_space == 2'd1));

    assert_code_write_illegal_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_mode >= 3'd5) |=> out_illegal);
endmodule

bind oper_addr_gen agu_checker #(
    .ADDR_W (ADDR_W),
    .RF_AW  (RF_AW),
    .BANK_W (BANK_W)
) i_chk (.*);

// File: tb/test_oper_addr_gen.sv
`timescale 1ns/1ps
module test_oper_addr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_mode;
    logic        req_write;
    logic        req_ext;
    logic [2:0]  req_reg;
    logic [7:0]  req_dir;
    logic [1:0]  bank_sel;
    logic [7:0]  sp;
    logic [15:0] dptr;
    logic [15:0] pc;
    logic [7:0]  acc;
    logic [4:0]  rf_addr;
    logic [7:0]  rf_rdata;
    logic        out_valid;
    logic [15:0] out_addr;
    logic [1:0]  out_space;
    logic        out_illegal;
    logic        out_jump;

    logic [7:0]  rf_mem [32];
    int          n_checks = 0;
    int          n_errors = 0;

    // expected result of the request issued at the previous negedge
    logic        pend;
    logic [19:0] exp_q;
    logic [19:0] last_q;
    string       exp_tag;

    always #4 clk = ~clk;

    assign rf_rdata = rf_mem[rf_addr];

    oper_addr_gen i_oper_addr_gen (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // packed {illegal, jump, space[1:0], addr[15:0]}
    function automatic logic [19:0] model(input logic [2:0] m, input logic w, input logic e,
                                          input logic [2:0] r, input logic [7:0] d,
                                          input logic [1:0] b, input logic [7:0] s,
                                          input logic [15:0] dp, input logic [15:0] p,
                                          input logic [7:0] a);
        logic [15:0] ad;
        logic [1:0]  spc;
        logic        j;
        j = 1'b0;
        case (m)
            3'd0: begin ad = 16'(b * 8 + r); spc = 2'd0; end
            3'd1: begin if (e) return {4'b1011, 16'h0}; ad = {8'h0, d}; spc = 2'd0; end
            3'd2: begin ad = {8'h0, rf_mem[b * 8 + r[0]]}; spc = e ? 2'd1 : 2'd0; end
            3'd3: begin ad = {8'h0, s}; spc = e ? 2'd1 : 2'd0; end
            3'd4: begin ad = dp; spc = 2'd1; end
            3'd5: begin if (w) return {4'b1011, 16'h0}; ad = 16'((32'(dp) + 32'(a)) % 65536); spc = 2'd2; end
            3'd6: begin if (w) return {4'b1011, 16'h0}; ad = 16'((32'(p) + 32'(a)) % 65536); spc = 2'd2; end
            default: begin if (w) return {4'b1011, 16'h0}; ad = 16'((32'(dp) + 32'(a)) % 65536); spc = 2'd2; j = 1'b1; end
        endcase
        return {1'b0, j, spc, ad};
    endfunction

    function automatic string tag_of(input logic [2:0] m, input logic w, input logic e);
        if ((m == 3'd1 && e) || (m >= 3'd5 && w)) return "R9";
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5, 3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    // At a negedge: judge the previous cycle, then drive the next one.
    task automatic step(input logic v, input logic [2:0] m, input logic w, input logic e,
                        input logic [2:0] r, input logic [7:0] d, input logic [1:0] b,
                        input logic [7:0] s, input logic [15:0] dp, input logic [15:0] p,
                        input logic [7:0] a);
        @(negedge clk);
        check("R10 valid", 32'(out_valid), 32'(pend));
        if (pend) begin
            check({exp_tag, " addr"},    32'(out_addr),    32'(exp_q[15:0]));
            check({exp_tag, " space"},   32'(out_space),   32'(exp_q[17:16]));
            check({exp_tag, " jump"},    32'(out_jump),    32'(exp_q[18]));
            check({exp_tag, " illegal"}, 32'(out_illegal), 32'(exp_q[19]));
            last_q = exp_q;
        end else begin
            check("R10 hold", 32'({out_illegal, out_jump, out_space, out_addr}), 32'(last_q));
        end
        req_valid = v; req_mode = m; req_write = w; req_ext = e; req_reg = r;
        req_dir = d; bank_sel = b; sp = s; dptr = dp; pc = p; acc = a;
        pend = v;
        exp_q = model(m, w, e, r, d, b, s, dp, p, a);
        exp_tag = tag_of(m, w, e);
        if (v && m == 3'd2) begin
            #1;
            check("R4 rf_addr", 32'(rf_addr), 32'(b * 8 + r[0]));
        end
    endtask

    initial begin
        #(200000 * 8);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) rf_mem[i] = 8'($urandom);
        rst = 1'b1; req_valid = 1'b0; req_mode = '0; req_write = 1'b0; req_ext = 1'b0;
        req_reg = '0; req_dir = '0; bank_sel = '0; sp = '0; dptr = '0; pc = '0; acc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid",   32'(out_valid),   32'd0);
        check("R1 illegal", 32'(out_illegal), 32'd0);
        check("R1 jump",    32'(out_jump),    32'd0);
        check("R1 addr",    32'(out_addr),    32'd0);
        check("R1 space",   32'(out_space),   32'd3);
        rst = 1'b0;
        pend = 1'b0;
        last_q = {4'b0011, 16'h0};

        // directed corner cases, back to back
        step(1, 3'd0, 1, 1, 3'd7, 8'h00, 2'd3, 8'h00, 16'h0000, 16'h0000, 8'h00); // R2 -> 31
        step(1, 3'd1, 0, 1, 3'd0, 8'h7F, 2'd0, 8'h00, 16'h0000, 16'h0000, 8'h00); // R3 ext -> illegal
        step(1, 3'd1, 1, 0, 3'd0, 8'hA5, 2'd0, 8'h00, 16'h0000, 16'h0000, 8'h00); // R3
        step(1, 3'd2, 0, 0, 3'd1, 8'h00, 2'd2, 8'h00, 16'h0000, 16'h0000, 8'h00); // R4 bank 2 R1
        step(1, 3'd2, 0, 1, 3'd6, 8'h00, 2'd1, 8'h00, 16'h0000, 16'h0000, 8'h00); // R4 bank switch, R0
        step(1, 3'd3, 0, 1, 3'd0, 8'h00, 2'd0, 8'h81, 16'h0000, 16'h0000, 8'h00); // R5 external
        step(1, 3'd4, 1, 0, 3'd0, 8'h00, 2'd0, 8'h00, 16'hBEEF, 16'h0000, 8'h00); // R6
        step(1, 3'd5, 0, 0, 3'd0, 8'h00, 2'd0, 8'h00, 16'hFFFF, 16'h1234, 8'hFF); // R7 wrap -> 00FE
        step(1, 3'd6, 0, 0, 3'd0, 8'h00, 2'd0, 8'h00, 16'hFFFF, 16'hFF80, 8'h80); // R7 pc wrap -> 0000
        step(1, 3'd6, 1, 0, 3'd0, 8'h00, 2'd0, 8'h00, 16'h0000, 16'h0100, 8'h01); // R7 write -> illegal
        step(1, 3'd7, 0, 0, 3'd0, 8'h00, 2'd0, 8'h00, 16'h1234, 16'h0000, 8'h80); // R8 -> 12B4
        step(0, 3'd7, 1, 0, 3'd0, 8'h00, 2'd0, 8'h00, 16'h0000, 16'h0000, 8'h00); // idle
        step(1, 3'd7, 1, 0, 3'd0, 8'h00, 2'd0, 8'h00, 16'h1234, 16'h0000, 8'h80); // R8 write -> R9
        step(0, 3'd0, 0, 0, 3'd0, 8'h00, 2'd3, 8'h00, 16'h0000, 16'h0000, 8'h00); // idle, R10 hold
        step(0, 3'd2, 0, 0, 3'd0, 8'h00, 2'd1, 8'h00, 16'h0000, 16'h0000, 8'h00); // R10 hold again

        // seeded random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[3:0] != 4'd0, rv[6:4], rv[7] & rv[8], rv[9], rv[12:10], 8'($urandom),
                 rv[14:13], 8'($urandom), 16'($urandom), 16'($urandom), 8'($urandom));
        end
        step(0, 3'd0, 0, 0, 3'd0, 8'h00, 2'd0, 8'h00, 16'h0000, 16'h0000, 8'h00);
        step(0, 3'd0, 0, 0, 3'd0, 8'h00, 2'd0, 8'h00, 16'h0000, 16'h0000, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule